// File: doc/BRIEF.md
# Tagged Receive Character Queue

This block is the receive-side character store of an 8N1 high-speed serial port (8 data bits, no parity, one stop bit). The deserializer hands it one character at a time with a strobe, together with two tags: one saying the stop bit was bad (framing error) and one saying the character was a line break. Each character is held with its own tags, so a host can tell exactly which character in the stream was damaged.

On the bus side, the head of the queue is always visible as a packed read word. A pop strobe consumes the head. The host empties the queue by reading and popping until the read word shows the empty bit. A second word packs the receive occupancy together with a transmit occupancy supplied from outside, so that one read reports both directions.

Top module: `hsu_rx_fifo`

## Requirements
- R1: After reset the queue is empty: the read word equals 0x100, the low byte of the level word is 0 and `ovr_pulse` is low.
- R2: While the queue holds characters, the read word shows the head character in bits 7:0, its framing-error tag in bit 9, its break tag in bit 10 and a 0 in bit 8.
- R3: Characters leave the queue in the order they were accepted, and each pop takes exactly one.
- R4: While the queue is empty, the read word has bit 8 set and all other bits 0, and a pop has no effect: the next accepted character is the next one read.
- R5: A character strobed while the queue already holds 64 entries and no pop is accepted in the same cycle is dropped and does not change the stored contents. `ovr_pulse` is high during exactly the one cycle that follows each such drop.
- R6: The level word carries the receive occupancy in bits 7:0 and the `tx_level` input, zero-extended, in bits 15:8.
- R7: The receive occupancy stays between 0 and 64, changes by at most one per cycle, and never wraps.
- R8: A push and a pop in the same cycle on a full queue are both accepted (no drop, occupancy stays 64). On an empty queue the pop is ignored and the push is accepted (occupancy becomes 1).
- R9: The two tags are stored per entry: tags of one character never appear on another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chr_stb | input | 1 | A received character is present this cycle |
| chr_data | input | 8 | Received character |
| chr_ferr | input | 1 | Character had a bad stop bit |
| chr_brk | input | 1 | Character is break data |
| pop | input | 1 | Consume the head character |
| tx_level | input | 7 | Transmit-side occupancy, 0 to 64 |
| rd_word | output | 11 | Head character, empty bit and tags |
| level_word | output | 16 | Transmit and receive occupancy |
| ovr_pulse | output | 1 | One-cycle indication of a dropped character |

## Verification
The assertions take for granted that the strobes are clean single-cycle-qualified levels sampled at the clock and that `tx_level` never exceeds 64; the bench draws `tx_level` only from 0 to 64 and changes inputs only away from the rising edge. Random phases bias the push and pop rates so that the queue spends long stretches both empty and full, which drives the drop, the simultaneous push/pop on a full queue and the ignored pop on an empty queue, all predicted by a queue model in the bench.

// File: rtl/hsu_rx_pkg.sv
package hsu_rx_pkg;

  localparam int CHR_W  = 8;
  localparam int WORD_W = CHR_W + 3;

  typedef struct packed {
    logic             brk;
    logic             ferr;
    logic [CHR_W-1:0] chr;
  } rx_entry_t;

  // Read word: {brk, ferr, empty, chr}. An empty queue shows only the empty bit.
  function automatic logic [WORD_W-1:0] pack_read(input rx_entry_t e, input logic empty);
    logic [WORD_W-1:0] w;
    if (empty) w = {2'b00, 1'b1, {CHR_W{1'b0}}};
    else       w = {e.brk, e.ferr, 1'b0, e.chr};
    return w;
  endfunction

  // Occupancy update: one in, one out, or both.
  function automatic int unsigned next_count(input int unsigned cnt, input logic in_ok,
                                             input logic out_ok);
    int unsigned n;
    n = cnt;
    if (in_ok && !out_ok) n = cnt + 1;
    if (out_ok && !in_ok) n = cnt - 1;
    return n;
  endfunction

  // Circular index step for any depth.
  function automatic int unsigned wrap_step(input int unsigned idx, input int unsigned depth);
    return (idx == depth - 1) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/hsu_rx_store.sv
module hsu_rx_store
  import hsu_rx_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_idx,
  input  rx_entry_t        wr_entry,
  input  logic [PTR_W-1:0] rd_idx,
  output rx_entry_t        rd_entry
);

  rx_entry_t slot [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) slot[wr_idx] <= wr_entry;
  end

  assign rd_entry = slot[rd_idx];

endmodule

// File: rtl/hsu_rx_ctrl.sv
module hsu_rx_ctrl
  import hsu_rx_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic             push_ok,
  output logic [PTR_W-1:0] wr_idx,
  output logic [PTR_W-1:0] rd_idx,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             ovr_q
);

  logic full;
  logic pop_ok;
  logic drop;

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign pop_ok  = pop && !empty;
  assign push_ok = push && (!full || pop_ok);
  assign drop    = push && !push_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx <= '0;
      rd_idx <= '0;
      count  <= '0;
      ovr_q  <= 1'b0;
    end else begin
      if (push_ok) wr_idx <= PTR_W'(wrap_step(int'(wr_idx), DEPTH));
      if (pop_ok)  rd_idx <= PTR_W'(wrap_step(int'(rd_idx), DEPTH));
      count <= CNT_W'(next_count(int'(count), push_ok, pop_ok));
      ovr_q <= drop;
    end
  end

  // R7: occupancy bounded by the depth
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R7: occupancy moves by at most one per cycle
  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (count == $past(count)) || (count == $past(count) + 1'b1) || (count + 1'b1 == $past(count)));

  // R5: a strobe into a full queue without a pop is flagged next cycle
  p_drop_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (ovr_q && count == CNT_W'(DEPTH)));

  // R5: the flag only follows a full queue
  p_flag_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |-> $past(full));

  // R4: a pop on an empty queue leaves it empty
  p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (count == '0 && $stable(rd_idx)));

endmodule

// File: rtl/hsu_rx_pack.sv
module hsu_rx_pack
  import hsu_rx_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LVL_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  rx_entry_t          head,
  input  logic               empty,
  input  logic [CNT_W-1:0]   rx_count,
  input  logic [CNT_W-1:0]   tx_count,
  output logic [WORD_W-1:0]  rd_word,
  output logic [2*LVL_W-1:0] level_word
);

  assign rd_word    = pack_read(head, empty);
  assign level_word = {LVL_W'(tx_count), LVL_W'(rx_count)};

endmodule

// File: rtl/hsu_rx_fifo.sv
module hsu_rx_fifo
  import hsu_rx_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LVL_W = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chr_stb,
  input  logic [CHR_W-1:0]   chr_data,
  input  logic               chr_ferr,
  input  logic               chr_brk,
  input  logic               pop,
  input  logic [CNT_W-1:0]   tx_level,
  output logic [WORD_W-1:0]  rd_word,
  output logic [2*LVL_W-1:0] level_word,
  output logic               ovr_pulse
);

  logic             push_ok;
  logic [PTR_W-1:0] wr_idx;
  logic [PTR_W-1:0] rd_idx;
  logic [CNT_W-1:0] rx_count;
  logic             empty;
  rx_entry_t        wr_entry;
  rx_entry_t        head;

  assign wr_entry = '{brk: chr_brk, ferr: chr_ferr, chr: chr_data};

  hsu_rx_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .push(chr_stb), .pop(pop), .push_ok(push_ok),
    .wr_idx(wr_idx), .rd_idx(rd_idx), .count(rx_count), .empty(empty), .ovr_q(ovr_pulse)
  );

  hsu_rx_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .wr_en(push_ok), .wr_idx(wr_idx), .wr_entry(wr_entry),
    .rd_idx(rd_idx), .rd_entry(head)
  );

  hsu_rx_pack #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_pack (
    .head(head), .empty(empty), .rx_count(rx_count), .tx_count(tx_level),
    .rd_word(rd_word), .level_word(level_word)
  );

  // R2: the empty bit of the read word agrees with the reported occupancy
  p_empty_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_word[CHR_W] == (level_word[LVL_W-1:0] == '0));

  // R4: an empty read word carries nothing but the empty bit
  p_empty_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_word[CHR_W] |-> (rd_word[CHR_W-1:0] == '0 && rd_word[WORD_W-1:CHR_W+1] == '0));

endmodule

// File: tb/test_hsu_rx_fifo.sv
module test_hsu_rx_fifo;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chr_stb = 1'b0;
  logic [7:0]  chr_data = '0;
  logic        chr_ferr = 1'b0;
  logic        chr_brk = 1'b0;
  logic        pop = 1'b0;
  logic [6:0]  tx_level = '0;
  logic [10:0] rd_word;
  logic [15:0] level_word;
  logic        ovr_pulse;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [9:0] mq[$];   // {brk, ferr, chr}
  bit exp_ovr = 1'b0;

  always #5 clk = ~clk;

  hsu_rx_fifo i_hsu_rx_fifo (
    .clk(clk), .rst_n(rst_n), .chr_stb(chr_stb), .chr_data(chr_data), .chr_ferr(chr_ferr),
    .chr_brk(chr_brk), .pop(pop), .tx_level(tx_level), .rd_word(rd_word),
    .level_word(level_word), .ovr_pulse(ovr_pulse)
  );

  function automatic logic [10:0] exp_read();
    if (mq.size() == 0) return 11'h100;
    return {mq[0][9], mq[0][8], 1'b0, mq[0][7:0]};
  endfunction

  function automatic logic [15:0] exp_level();
    return {1'b0, tx_level, 8'(mq.size())};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic check_all(input string rtag);
    check(rtag, {5'd0, rd_word}, {5'd0, exp_read()});
    check("R6", level_word, exp_level());
    check("R5", {15'd0, ovr_pulse}, {15'd0, exp_ovr});
    check("R7", {15'd0, (level_word[7:0] <= 8'd64)}, 16'd1);
  endtask

  // drive one cycle of stimulus at the falling edge, step the model, sample at the next falling edge
  task automatic cyc(input bit ps, input logic [7:0] d, input bit fe, input bit bk,
                     input bit pp, input logic [6:0] txc, input string rtag);
    bit pop_ok, push_ok;
    chr_stb = ps; chr_data = d; chr_ferr = fe; chr_brk = bk; pop = pp; tx_level = txc;
    pop_ok  = pp && (mq.size() > 0);
    push_ok = ps && ((mq.size() < 64) || pop_ok);
    if (pop_ok)  void'(mq.pop_front());
    if (push_ok) mq.push_back({bk, fe, d});
    exp_ovr = ps && !push_ok;
    @(posedge clk);
    @(negedge clk);
    check_all(rtag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", {5'd0, rd_word}, 16'h0100);
    check("R1", {8'd0, level_word[7:0]}, 16'd0);
    check("R1", {15'd0, ovr_pulse}, 16'd0);

    // R4: pops on empty are ignored
    repeat (3) cyc(0, 8'h00, 0, 0, 1, 7'd5, "R4");
    cyc(1, 8'h3C, 0, 0, 0, 7'd5, "R4");
    check("R4", {8'd0, rd_word[7:0]}, 16'h003C);

    // R2/R9: tag bits per entry
    cyc(1, 8'hA5, 1, 0, 0, 7'd0, "R2");
    cyc(1, 8'h5A, 0, 1, 0, 7'd0, "R2");
    cyc(0, 8'h00, 0, 0, 1, 7'd0, "R2");
    check("R2", {5'd0, rd_word}, 16'h02A5);
    cyc(0, 8'h00, 0, 0, 1, 7'd0, "R9");
    check("R9", {5'd0, rd_word}, 16'h045A);
    cyc(0, 8'h00, 0, 0, 1, 7'd0, "R4");
    check("R4", {5'd0, rd_word}, 16'h0100);

    // R8: push and pop together on an empty queue
    cyc(1, 8'h77, 0, 0, 1, 7'd64, "R8");
    check("R8", {8'd0, level_word[7:0]}, 16'd1);
    cyc(0, 8'h00, 0, 0, 1, 7'd64, "R8");

    // R5/R7: fill past capacity
    for (int i = 0; i < 67; i++) cyc(1, 8'(i), i[0], i[1], 0, 7'd3, "R3");
    check("R7", {8'd0, level_word[7:0]}, 16'd64);
    check("R5", {15'd0, ovr_pulse}, 16'd1);
    cyc(0, 8'h00, 0, 0, 0, 7'd3, "R5");
    check("R5", {15'd0, ovr_pulse}, 16'd0);

    // R8: push and pop together on a full queue
    cyc(1, 8'hEE, 1, 1, 1, 7'd3, "R8");
    check("R8", {8'd0, level_word[7:0]}, 16'd64);
    check("R8", {15'd0, ovr_pulse}, 16'd0);

    // R3: drain in order (dropped characters never appear)
    while (mq.size() > 0) cyc(0, 8'h00, 0, 0, 1, 7'd0, "R3");
    check("R3", {5'd0, rd_word}, 16'h0100);

    // random phases with varying push and pop rates
    for (int ph = 0; ph < 8; ph++) begin
      int unsigned pw = (ph % 2 == 0) ? 80 : 25;
      int unsigned pr = (ph % 2 == 0) ? 30 : 85;
      for (int k = 0; k < 600; k++) begin
        cyc(($urandom % 100) < pw, 8'($urandom), $urandom % 4 == 0, $urandom % 6 == 0,
            ($urandom % 100) < pr, 7'($urandom % 65), "R9");
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule